// File: doc/BRIEF.md
# ECC Sub-Word Store Squash

This block carries out narrow stores (8, 16 or 32 bits) into a data array in which every 64-bit word is protected by eight SECDED check bits. A narrow store cannot simply overwrite part of a protected word, so the block reads the whole word and its check bits and corrects any single-bit error. It then splices the new bytes into the corrected word and produces fresh check bits for the result before it writes.

While the check bits are being produced, the block also compares the spliced word with the corrected original. If the two match and the read was clean, the store changes nothing and the array write is dropped (squashed). A corrected single-bit error always forces the write, so the location is scrubbed. An uncorrectable error is reported, and nothing is written. Only one store is in flight at a time, and `busy_o` holds off new requests.

Top module: `ecc_store_squash`

## Requirements
- R1: A request accepted at a clock edge (`req_valid_i` high, `busy_o` low) drives `arr_rd_en_o` with the word address `req_addr_i[ADDR_W-1:3]` in the following cycle. `done_o` pulses for exactly one cycle two cycles after that read cycle, together with any array write. A read and a write never occur in the same cycle.
- R2: `busy_o` is high from the cycle after acceptance through the `done_o` cycle and low in the cycle after it. Requests presented while `busy_o` is high are ignored: they produce no read, no write and no `done_o`.
- R3: The size code selects the lanes. 0 is a byte at byte offset `addr[2:0]`. 1 is a halfword at byte offset `{addr[2:1],0}`. 2 and 3 are a 32-bit word at byte offset `{addr[2],00}`. Address bits below the access size are ignored. Store data comes from the low bits of `req_data_i`, and the other bytes keep their corrected original values.
- R4: Number the codeword positions 1..71. Data bit i occupies the i-th position (counting from 0) among the positions that are not powers of two, starting at 3. Check bit k (k = 0..6) is the XOR of the data bits whose position has bit k set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6. The written check bits follow this code for the written data.
- R5: When the read is clean and the merged word equals the original word, no write occurs and `squash_o` is high in the `done_o` cycle.
- R6: When the read is clean and the merged word differs from the original, the merged word and its check bits are written, and `squash_o` is low.
- R7: A single-bit error, whether in a data bit or a check bit, is corrected before the merge. `corr_o` is high in the `done_o` cycle, and the write always happens, even for a store that would otherwise be silent.
- R8: A double-bit error raises `dbl_err_o` in the `done_o` cycle. Neither a write nor a squash is reported, and the array word is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Store request valid |
| req_addr_i | input | ADDR_W | Store byte address |
| req_size_i | input | 2 | Size code: 0 byte, 1 half, 2 or 3 word |
| req_data_i | input | 32 | Store data, right-aligned |
| busy_o | output | 1 | Sequence in progress; requests ignored |
| arr_rd_en_o | output | 1 | Array read strobe |
| arr_addr_o | output | ADDR_W-3 | Array word address |
| arr_rd_data_i | input | 64 | Read data, valid the cycle after the strobe |
| arr_rd_chk_i | input | 8 | Read check bits, same timing |
| arr_wr_en_o | output | 1 | Array write strobe |
| arr_wr_data_o | output | 64 | Write data |
| arr_wr_chk_o | output | 8 | Write check bits |
| done_o | output | 1 | Sequence finished this cycle |
| squash_o | output | 1 | Store was silent; write skipped |
| corr_o | output | 1 | Single-bit error corrected |
| dbl_err_o | output | 1 | Uncorrectable error detected |

## Verification
The bench targets silent stores that arrive on a word with a single-bit error. A design that compared against the raw read word, or that let silence override the error, would squash these stores and leave the flipped bit in place. Errors injected into a check bit alone test whether the decoder tells apart a check-bit error from a data-bit error; a design that got this wrong would corrupt a data bit. Double-bit errors must produce no write, and a design that wrote the merged word would hide the corruption under valid check bits. Misaligned addresses, size code 3 and requests held high while the block is busy expose lane-select errors and any requests that slip through.

// File: rtl/ecc_sq_pkg.sv
package ecc_sq_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned CHK_W  = 8;
  localparam int unsigned HAM_W  = 7;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MERGE = 2'd2,
    ST_WRITE = 2'd3
  } sq_state_e;

  // codeword position of data bit idx: non-powers of two from 3 upward
  function automatic logic [HAM_W-1:0] data_pos(int unsigned idx);
    logic [HAM_W-1:0] r;
    int unsigned n;
    r = '0;
    n = 0;
    for (int unsigned p = 3; p < 128; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) r = p[HAM_W-1:0];
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] chk_mask(int unsigned k);
    logic [DATA_W-1:0] m;
    logic [HAM_W-1:0]  p;
    m = '0;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      p    = data_pos(i);
      m[i] = p[k];
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_sq_encode.sv
module ecc_sq_encode
  import ecc_sq_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  logic [HAM_W-1:0] ham;

  for (genvar k = 0; k < HAM_W; k++) begin : g_ham
    localparam logic [DATA_W-1:0] MASK = chk_mask(k);
    assign ham[k] = ^(data_i & MASK);
  end

  assign chk_o = {^{data_i, ham}, ham};
endmodule

// File: rtl/ecc_sq_decode.sv
module ecc_sq_decode
  import ecc_sq_pkg::*;
(
  input  logic [DATA_W-1:0] raw_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              corr_o,
  output logic              dbl_o
);
  logic [HAM_W-1:0]  ham;
  logic [HAM_W-1:0]  syn;
  logic [DATA_W-1:0] flip;
  logic              par_err;
  logic              bad_syn;

  for (genvar k = 0; k < HAM_W; k++) begin : g_syn
    localparam logic [DATA_W-1:0] MASK = chk_mask(k);
    assign ham[k] = ^(raw_i & MASK);
  end

  assign syn     = ham ^ chk_i[HAM_W-1:0];
  assign par_err = ^{raw_i, chk_i};
  assign bad_syn = syn > HAM_W'(71);

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam logic [HAM_W-1:0] POS = data_pos(i);
    assign flip[i] = par_err && (syn == POS);
  end

  assign data_o = raw_i ^ flip;
  // odd parity: single error (data or check bit); even parity with syndrome: double
  assign corr_o = par_err && !bad_syn;
  assign dbl_o  = (!par_err && (syn != '0)) || (par_err && bad_syn);
endmodule

// File: rtl/ecc_sq_merge.sv
module ecc_sq_merge
  import ecc_sq_pkg::*;
(
  input  logic [DATA_W-1:0] orig_i,
  input  logic [2:0]        off_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       data_i,
  output logic [DATA_W-1:0] merged_o
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam logic [2:0] LB = 3'(b);
    localparam int unsigned H = b % 2;
    localparam int unsigned W = b % 4;
    logic       en;
    logic [7:0] src;

    always_comb begin
      unique case (size_i)
        2'd0: begin
          en  = (off_i == LB);
          src = data_i[7:0];
        end
        2'd1: begin
          en  = (off_i[2:1] == LB[2:1]);
          src = data_i[8*H +: 8];
        end
        default: begin
          en  = (off_i[2] == LB[2]);
          src = data_i[8*W +: 8];
        end
      endcase
    end

    assign merged_o[8*b +: 8] = en ? src : orig_i[8*b +: 8];
  end
endmodule

// File: rtl/ecc_sq_ctrl.sv
module ecc_sq_ctrl
  import ecc_sq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_valid_i,
  output logic      accept_o,
  output logic      busy_o,
  output sq_state_e state_o
);
  sq_state_e state_q, state_d;

  assign busy_o   = (state_q != ST_IDLE);
  assign accept_o = req_valid_i && !busy_o;
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = ST_READ;
      ST_READ:  state_d = ST_MERGE;
      ST_MERGE: state_d = ST_WRITE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/ecc_store_squash.sv
module ecc_store_squash
  import ecc_sq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [31:0]       req_data_i,
  output logic              busy_o,
  output logic              arr_rd_en_o,
  output logic [ADDR_W-4:0] arr_addr_o,
  input  logic [63:0]       arr_rd_data_i,
  input  logic [7:0]        arr_rd_chk_i,
  output logic              arr_wr_en_o,
  output logic [63:0]       arr_wr_data_o,
  output logic [7:0]        arr_wr_chk_o,
  output logic              done_o,
  output logic              squash_o,
  output logic              corr_o,
  output logic              dbl_err_o
);
  sq_state_e         state;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [31:0]       data_q;

  logic [DATA_W-1:0] fixed;
  logic              dec_corr, dec_dbl;
  logic [DATA_W-1:0] merged;
  logic [CHK_W-1:0]  new_chk;
  logic              silent;

  logic [DATA_W-1:0] merged_q;
  logic [CHK_W-1:0]  chk_q;
  logic              wr_q, squash_q, corr_q, dbl_q;

  ecc_sq_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .state_o    (state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      size_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr_i;
      size_q <= req_size_i;
      data_q <= req_data_i;
    end
  end

  ecc_sq_decode u_dec (
    .raw_i (arr_rd_data_i),
    .chk_i (arr_rd_chk_i),
    .data_o(fixed),
    .corr_o(dec_corr),
    .dbl_o (dec_dbl)
  );

  ecc_sq_merge u_merge (
    .orig_i  (fixed),
    .off_i   (addr_q[2:0]),
    .size_i  (size_q),
    .data_i  (data_q),
    .merged_o(merged)
  );

  ecc_sq_encode u_enc (
    .data_i(merged),
    .chk_o (new_chk)
  );

  // silence compare in parallel with check-bit generation
  assign silent = (merged == fixed);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      merged_q <= '0;
      chk_q    <= '0;
      wr_q     <= 1'b0;
      squash_q <= 1'b0;
      corr_q   <= 1'b0;
      dbl_q    <= 1'b0;
    end else if (state == ST_MERGE) begin
      merged_q <= merged;
      chk_q    <= new_chk;
      wr_q     <= !dec_dbl && (!silent || dec_corr);
      squash_q <= !dec_dbl && silent && !dec_corr;
      corr_q   <= dec_corr;
      dbl_q    <= dec_dbl;
    end
  end

  assign arr_rd_en_o   = (state == ST_READ);
  assign arr_addr_o    = addr_q[ADDR_W-1:3];
  assign done_o        = (state == ST_WRITE);
  assign arr_wr_en_o   = done_o && wr_q;
  assign arr_wr_data_o = merged_q;
  assign arr_wr_chk_o  = chk_q;
  assign squash_o      = done_o && squash_q;
  assign corr_o        = done_o && corr_q;
  assign dbl_err_o     = done_o && dbl_q;
endmodule

// File: rtl/ecc_store_squash_chk.sv
module ecc_store_squash_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic busy_o,
  input logic arr_rd_en_o,
  input logic arr_wr_en_o,
  input logic done_o,
  input logic squash_o,
  input logic corr_o,
  input logic dbl_err_o
);
  assert_read_after_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> arr_rd_en_o);

  assert_done_after_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_rd_en_o |=> ##1 done_o);

  assert_rd_wr_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({arr_rd_en_o, arr_wr_en_o}));

  assert_busy_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  assert_done_ends_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  assert_squash_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> (done_o && !arr_wr_en_o));

  assert_write_in_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_en_o |-> done_o);

  assert_scrub_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o |-> arr_wr_en_o);

  assert_dbl_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_err_o |-> (!arr_wr_en_o && !squash_o));
endmodule

bind ecc_store_squash ecc_store_squash_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .busy_o     (busy_o),
  .arr_rd_en_o(arr_rd_en_o),
  .arr_wr_en_o(arr_wr_en_o),
  .done_o     (done_o),
  .squash_o   (squash_o),
  .corr_o     (corr_o),
  .dbl_err_o  (dbl_err_o)
);

// File: tb/ecc_store_squash_bench.sv
module ecc_store_squash_bench;
  localparam int AW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [1:0]    req_size_i = '0;
  logic [31:0]   req_data_i = '0;
  logic          busy_o, arr_rd_en_o, arr_wr_en_o, done_o, squash_o, corr_o, dbl_err_o;
  logic [AW-4:0] arr_addr_o;
  logic [63:0]   arr_rd_data_i, arr_wr_data_o;
  logic [7:0]    arr_rd_chk_i, arr_wr_chk_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  ecc_store_squash #(.ADDR_W(AW)) u_ecc_store_squash (.*);

  // array model: registered read, write at edge
  logic [71:0] mem [0:15];
  logic [63:0] golden [0:15];

  always @(posedge clk_i) begin
    if (arr_rd_en_o) {arr_rd_chk_i, arr_rd_data_i} <= mem[arr_addr_o[3:0]];
    if (arr_wr_en_o) mem[arr_addr_o[3:0]] <= {arr_wr_chk_o, arr_wr_data_o};
  end

  function automatic logic [7:0] enc(logic [63:0] d);
    logic [71:1] cw;
    logic [7:0]  c;
    int          j;
    cw = '0;
    c  = '0;
    j  = 0;
    for (int p = 1; p <= 71; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[j];
        j++;
      end
    end
    for (int p = 1; p <= 71; p++)
      for (int k = 0; k < 7; k++)
        if (p[k]) c[k] = c[k] ^ cw[p];
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  function automatic logic [63:0] merge(logic [63:0] o, logic [AW-1:0] a, logic [1:0] sz,
                                        logic [31:0] d);
    logic [63:0] r;
    r = o;
    case (sz)
      2'd0:    r[8*a[2:0] +: 8] = d[7:0];
      2'd1:    r[16*a[2:1] +: 16] = d[15:0];
      default: r[32*a[2] +: 32] = d;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] lane_of(logic [63:0] o, logic [AW-1:0] a, logic [1:0] sz);
    case (sz)
      2'd0:    return {24'h0, o[8*a[2:0] +: 8]};
      2'd1:    return {16'h0, o[16*a[2:1] +: 16]};
      default: return o[32*a[2] +: 32];
    endcase
  endfunction

  typedef struct {
    logic        wr;
    logic [63:0] data;
    logic [7:0]  chk;
    logic        squash;
    logic        corr;
    logic        dbl;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [71:0] act, input logic [71:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // monitor: pop expected item on every done
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected done", 72'(done_o), 72'(0));
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(arr_wr_en_o == e.wr, t, "write enable", 72'(arr_wr_en_o), 72'(e.wr));
        check(squash_o == e.squash, t, "squash", 72'(squash_o), 72'(e.squash));
        check(corr_o == e.corr, t, "corrected", 72'(corr_o), 72'(e.corr));
        check(dbl_err_o == e.dbl, t, "double error", 72'(dbl_err_o), 72'(e.dbl));
        if (e.wr) begin
          check(arr_wr_data_o == e.data, t, "write data", 72'(arr_wr_data_o), 72'(e.data));
          check(arr_wr_chk_o == e.chk, "R4", "check bits", 72'(arr_wr_chk_o), 72'(e.chk));
        end
      end
    end
  end

  // kind: 0 clean, 1 data bit, 2 check bit, 3 double
  task automatic store(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] d,
                       input int kind, input bit hold, input string tag);
    int          idx;
    exp_t        e;
    logic [63:0] m;
    bit          silent;
    idx = int'(a[6:3]);
    @(negedge clk_i);
    mem[idx] = {enc(golden[idx]), golden[idx]};
    case (kind)
      1: mem[idx][17] = ~mem[idx][17];
      2: mem[idx][67] = ~mem[idx][67];
      3: begin mem[idx][3] = ~mem[idx][3]; mem[idx][40] = ~mem[idx][40]; end
      default: ;
    endcase
    m        = merge(golden[idx], a, sz, d);
    silent   = (m == golden[idx]);
    e.corr   = (kind == 1 || kind == 2);
    e.dbl    = (kind == 3);
    e.wr     = !e.dbl && (!silent || e.corr);
    e.squash = !e.dbl && silent && !e.corr;
    e.data   = m;
    e.chk    = enc(m);
    if (e.wr) golden[idx] = m;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    req_size_i  = sz;
    req_data_i  = d;
    @(negedge clk_i);
    check(arr_rd_en_o && busy_o, "R1", "read strobe", 72'({arr_rd_en_o, busy_o}), 72'(3));
    check(arr_addr_o == a[AW-1:3], "R1", "read address", 72'(arr_addr_o), 72'(a[AW-1:3]));
    if (hold) begin
      req_addr_i = 12'h050;
      req_size_i = 2'd2;
      req_data_i = 32'hFFFF_0000;
    end else begin
      req_valid_i = 1'b0;
    end
    @(negedge clk_i);
    check(!arr_rd_en_o && busy_o && !done_o, "R2", "merge cycle",
          72'({arr_rd_en_o, busy_o, done_o}), 72'(3'b010));
    @(negedge clk_i);
    check(done_o == 1'b1, "R1", "done timing", 72'(done_o), 72'(1));
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check(!busy_o && !done_o && !arr_rd_en_o, "R2", "idle after done",
          72'({busy_o, done_o, arr_rd_en_o}), 72'(0));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      golden[i] = {32'h0F1E2D3C ^ 32'(i), 32'hA5A55A5A + 32'(i)};
      mem[i]    = {enc(golden[i]), golden[i]};
    end
    repeat (3) @(negedge clk_i);
    check(!busy_o && !arr_rd_en_o && !arr_wr_en_o && !done_o, "R2", "reset state",
          72'({busy_o, arr_rd_en_o, arr_wr_en_o, done_o}), 72'(0));
    rst_ni = 1'b1;

    store(12'h00D, 2'd0, ~lane_of(golden[1], 12'h00D, 2'd0), 0, 0, "R6");
    store(12'h00A, 2'd1, lane_of(golden[1], 12'h00A, 2'd1), 0, 0, "R5");
    store(12'h014, 2'd2, 32'hDEADBEEF, 0, 0, "R6");
    store(12'h010, 2'd2, lane_of(golden[2], 12'h010, 2'd2), 0, 0, "R5");
    store(12'h01B, 2'd1, 32'hFFFF_1234, 0, 0, "R3");
    store(12'h026, 2'd3, 32'h600D_F00D, 0, 0, "R3");
    store(12'h02A, 2'd0, lane_of(golden[5], 12'h02A, 2'd0), 1, 0, "R7");
    store(12'h031, 2'd0, lane_of(golden[6], 12'h031, 2'd0), 2, 0, "R7");
    store(12'h03C, 2'd2, 32'h1357_9BDF, 1, 0, "R7");
    store(12'h045, 2'd0, 32'h0000_0099, 3, 0, "R8");
    begin
      logic [71:0] want;
      want = {enc(golden[8]), golden[8]};
      want[3]  = ~want[3];
      want[40] = ~want[40];
      check(mem[8] == want, "R8", "array untouched", mem[8], want);
    end
    store(12'h048, 2'd1, 32'h0000_ABCD, 0, 1, "R2");
    check(mem[10] == {enc(golden[10]), golden[10]}, "R2", "held request ignored",
          mem[10], {enc(golden[10]), golden[10]});
    store(12'h05F, 2'd0, 32'h0000_003C, 0, 0, "R4");
    store(12'h059, 2'd0, 32'h0000_00C3, 0, 0, "R4");

    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R1", "all results seen", 72'(exp_q.size()), 72'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL R1 watchdog expired: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule